// File: doc/BRIEF.md
# Undervoltage Hiccup Protection Controller

This block guards a power converter's system rail against a short or heavy overload. It watches a synchronized comparator flag that reports a low rail. A low rail that persists for a qualifying interval raises a request to clamp the input current limit to its reduced level (about 0.5 A in the target system). The controller then cycles the converter off and on: a long shutdown window is followed by a short restart window. After each restart window the rail is judged again.

Every restart that ends with the rail still low counts as a failure, and each failure is stamped in a small history. When a set number of failures fall inside a sliding long window, the controller latches the converter off and raises a sticky fault bit. A configuration input can select latch-off straight after qualification, with no retry. Only a host write of zero to the fault bit releases the latch. A disable input turns all detection off and lets the converter run. All durations are counted in ticks of a prescaled millisecond timebase, and every duration is a parameter.

Top module: `uv_hiccup_guard`

## Requirements
- R1: Out of reset, convEn is 1, clampReq is 0 and faultBit is 0, and detection is active.
- R2: While uvDisable is 1, the flag is ignored: from the cycle after uvDisable is first seen at a clock edge, convEn is 1 and clampReq is 0.
- R3: The flag qualifies only after it has been seen high on DEGLITCH_TICKS*CLKS_PER_TICK consecutive clock edges. A single low sample restarts the count, and a shorter pulse has no effect on the outputs.
- R4: On qualification clampReq goes to 1. It stays at 1 through every shutdown, restart and latched cycle, and it drops only on recovery, on a host clear or on disable.
- R5: In hiccup operation (noHiccup = 0), qualification sets convEn to 0 for SHUTDOWN_TICKS*CLKS_PER_TICK cycles. convEn then returns to 1 for a restart window of RESTART_TICKS*CLKS_PER_TICK cycles.
- R6: The flag is sampled only in the last cycle of a restart window. If it is high, the attempt fails and a new shutdown window starts. If it is low, the block goes back to monitoring, with convEn 1 and clampReq 0.
- R7: A failure latches the block off (convEn 0, faultBit 1) when it is the MAX_FAILS-th failure in a row whose oldest member lies no more than WINDOW_TICKS ticks earlier. Failures older than that do not count.
- R8: With noHiccup = 1, qualification latches the block off at once (convEn 0, faultBit 1) and no shutdown or restart window follows.
- R9: While latched, convEn stays 0 and faultBit stays 1 whatever the flag does. A host write (faultWrEn = 1) with faultWrData = 1 has no effect.
- R10: A host write with faultWrData = 0 clears faultBit. A latched block returns to monitoring on the next cycle, with convEn 1 and clampReq 0.
- R11: Disabling a latched block releases the converter (convEn 1) but keeps faultBit at 1. Re-enabling before a host clear returns the block to latch-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvFlag | input | 1 | Synchronized low-rail comparator flag, 1 = rail low |
| uvDisable | input | 1 | Configuration: 1 turns protection off and forces idle |
| noHiccup | input | 1 | Configuration: 1 latches off right after qualification |
| faultWrEn | input | 1 | Host write strobe for the fault bit |
| faultWrData | input | 1 | Value written to the fault bit; only 0 acts |
| convEn | output | 1 | Converter enable, 0 = converter held off |
| clampReq | output | 1 | Request to clamp the input current limit to its reduced level |
| faultBit | output | 1 | Sticky latch-off fault status |

## Verification
The bench uses CLKS_PER_TICK = 2, DEGLITCH_TICKS = 3, SHUTDOWN_TICKS = 8, RESTART_TICKS = 4, WINDOW_TICKS = 30 and MAX_FAILS = 3. A full hiccup period is then 24 cycles, and a three-failure latch-off arrives within about 80 cycles. With these values, three failures spaced 12 ticks apart (oldest 24 ticks back, inside the 30-tick window) can be set against failures pushed 40 ticks apart by a recovery in between. The non-unit prescaler also checks that every window length is an exact multiple of the tick period.

// File: rtl/uvh_pkg.sv
package uvh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MONITOR,
    ST_DEGLITCH,
    ST_SHUTDOWN,
    ST_RESTART,
    ST_LATCHED
  } uvhState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restartTimer; // zero prescaler and phase counter (state change)
    logic logFail;      // stamp a failed restart into the history
    logic clearHist;    // drop every stamped failure
  } uvhStrobe_t;

endpackage

// File: rtl/uvh_datapath.sv
module uvh_datapath
  import uvh_pkg::*;
#(
  parameter int CLKS_PER_TICK  = 1000,
  parameter int DEGLITCH_TICKS = 2,
  parameter int SHUTDOWN_TICKS = 500,
  parameter int RESTART_TICKS  = 10,
  parameter int WINDOW_TICKS   = 90000,
  parameter int MAX_FAILS      = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  uvhStrobe_t strobe,
  output logic       deglitchDone,
  output logic       shutdownDone,
  output logic       restartDone,
  output logic       windowFull
);

  localparam int PRE_W   = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int LONG_A  = (DEGLITCH_TICKS > RESTART_TICKS) ? DEGLITCH_TICKS : RESTART_TICKS;
  localparam int LONGEST = (LONG_A > SHUTDOWN_TICKS) ? LONG_A : SHUTDOWN_TICKS;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int STAMP_W = $clog2(WINDOW_TICKS + 1) + 1;
  localparam int IDX_W   = (MAX_FAILS > 1) ? $clog2(MAX_FAILS) : 1;

  localparam logic [PRE_W-1:0]   PRE_LAST  = PRE_W'(CLKS_PER_TICK - 1);
  localparam logic [TMR_W-1:0]   TMR_MAX   = TMR_W'(LONGEST);
  localparam logic [TMR_W-1:0]   DEG_LAST  = TMR_W'(DEGLITCH_TICKS - 1);
  localparam logic [TMR_W-1:0]   SHUT_LAST = TMR_W'(SHUTDOWN_TICKS - 1);
  localparam logic [TMR_W-1:0]   RST_LAST  = TMR_W'(RESTART_TICKS - 1);
  localparam logic [STAMP_W-1:0] WIN_LIM   = STAMP_W'(WINDOW_TICKS);
  localparam logic [IDX_W-1:0]   IDX_LAST  = IDX_W'(MAX_FAILS - 1);

  logic [PRE_W-1:0]   preCnt;
  logic               tick;
  logic [TMR_W-1:0]   phaseCnt;
  logic [STAMP_W-1:0] nowCnt;
  logic [IDX_W-1:0]   wrPtr;
  logic [IDX_W-1:0]   oldIdx;
  logic [STAMP_W-1:0] stampArr [MAX_FAILS];
  logic [STAMP_W-1:0] ageArr   [MAX_FAILS];
  logic               validArr [MAX_FAILS];

  // Prescaler re-phased on every state change so each window is exact
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     preCnt <= '0;
    else if (strobe.restartTimer)  preCnt <= '0;
    else if (preCnt == PRE_LAST)   preCnt <= '0;
    else                           preCnt <= preCnt + PRE_W'(1);
  end

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              phaseCnt <= '0;
    else if (strobe.restartTimer)           phaseCnt <= '0;
    else if (tick && phaseCnt != TMR_MAX)   phaseCnt <= phaseCnt + TMR_W'(1);
  end

  always_comb begin
    deglitchDone = tick && (phaseCnt == DEG_LAST);
    shutdownDone = tick && (phaseCnt == SHUT_LAST);
    restartDone  = tick && (phaseCnt == RST_LAST);
  end

  // Free-running tick stamp, compared modulo its width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     nowCnt <= '0;
    else if (tick) nowCnt <= nowCnt + STAMP_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wrPtr <= '0;
    else if (strobe.clearHist)  wrPtr <= '0;
    else if (strobe.logFail)    wrPtr <= (wrPtr == IDX_LAST) ? '0 : wrPtr + IDX_W'(1);
  end

  generate
    for (genvar gi = 0; gi < MAX_FAILS; gi++) begin : g_hist
      assign ageArr[gi] = nowCnt - stampArr[gi];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stampArr[gi] <= '0;
          validArr[gi] <= 1'b0;
        end else if (strobe.clearHist) begin
          validArr[gi] <= 1'b0;
        end else if (strobe.logFail && wrPtr == IDX_W'(gi)) begin
          stampArr[gi] <= nowCnt;
          validArr[gi] <= 1'b1;
        end else if (validArr[gi] && ageArr[gi] > WIN_LIM) begin
          validArr[gi] <= 1'b0; // aged out before the stamp can alias
        end
      end
    end
  endgenerate

  // Slot after the write pointer holds the oldest of the newest MAX_FAILS-1
  always_comb begin
    oldIdx     = (wrPtr == IDX_LAST) ? '0 : wrPtr + IDX_W'(1);
    windowFull = validArr[oldIdx] && (ageArr[oldIdx] <= WIN_LIM);
  end

endmodule

// File: rtl/uvh_control.sv
module uvh_control
  import uvh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvFlag,
  input  logic       uvDisable,
  input  logic       noHiccup,
  input  logic       faultClear,
  input  logic       deglitchDone,
  input  logic       shutdownDone,
  input  logic       restartDone,
  input  logic       windowFull,
  output uvhStrobe_t strobe,
  output logic       convEn,
  output logic       clampReq,
  output logic       faultBit
);

  uvhState_e stateQ, stateNxt;
  logic      failNow;
  logic      enterLatch;

  always_comb begin
    stateNxt = stateQ;
    failNow  = 1'b0;
    if (uvDisable) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE:     stateNxt = (faultBit && !faultClear) ? ST_LATCHED : ST_MONITOR;
        ST_MONITOR:  if (uvFlag) stateNxt = ST_DEGLITCH;
        ST_DEGLITCH: begin
          if (!uvFlag)           stateNxt = ST_MONITOR;
          else if (deglitchDone) stateNxt = noHiccup ? ST_LATCHED : ST_SHUTDOWN;
        end
        ST_SHUTDOWN: if (shutdownDone) stateNxt = ST_RESTART;
        ST_RESTART: begin
          if (restartDone) begin
            if (uvFlag) begin
              failNow  = 1'b1;
              stateNxt = (noHiccup || windowFull) ? ST_LATCHED : ST_SHUTDOWN;
            end else begin
              stateNxt = ST_MONITOR;
            end
          end
        end
        ST_LATCHED:  if (faultClear) stateNxt = ST_MONITOR;
        default:     stateNxt = ST_IDLE;
      endcase
    end
  end

  assign enterLatch          = (stateNxt == ST_LATCHED) && (stateQ != ST_LATCHED);
  assign strobe.restartTimer = (stateNxt != stateQ);
  assign strobe.logFail      = failNow;
  assign strobe.clearHist    = enterLatch || (stateNxt == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_MONITOR;
    else       stateQ <= stateNxt;
  end

  // Latch entry wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           faultBit <= 1'b0;
    else if (enterLatch) faultBit <= 1'b1;
    else if (faultClear) faultBit <= 1'b0;
  end

  assign convEn   = !(stateQ == ST_SHUTDOWN || stateQ == ST_LATCHED);
  assign clampReq = (stateQ == ST_SHUTDOWN) || (stateQ == ST_RESTART) || (stateQ == ST_LATCHED);

endmodule

// File: rtl/uv_hiccup_guard.sv
module uv_hiccup_guard
  import uvh_pkg::*;
#(
  parameter int CLKS_PER_TICK  = 1000,
  parameter int DEGLITCH_TICKS = 2,
  parameter int SHUTDOWN_TICKS = 500,
  parameter int RESTART_TICKS  = 10,
  parameter int WINDOW_TICKS   = 90000,
  parameter int MAX_FAILS      = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic uvFlag,
  input  logic uvDisable,
  input  logic noHiccup,
  input  logic faultWrEn,
  input  logic faultWrData,
  output logic convEn,
  output logic clampReq,
  output logic faultBit
);

  uvhStrobe_t strobe;
  logic deglitchDone, shutdownDone, restartDone, windowFull;
  logic faultClear;

  assign faultClear = faultWrEn && !faultWrData;

  uvh_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .uvFlag       (uvFlag),
    .uvDisable    (uvDisable),
    .noHiccup     (noHiccup),
    .faultClear   (faultClear),
    .deglitchDone (deglitchDone),
    .shutdownDone (shutdownDone),
    .restartDone  (restartDone),
    .windowFull   (windowFull),
    .strobe       (strobe),
    .convEn       (convEn),
    .clampReq     (clampReq),
    .faultBit     (faultBit)
  );

  uvh_datapath #(
    .CLKS_PER_TICK  (CLKS_PER_TICK),
    .DEGLITCH_TICKS (DEGLITCH_TICKS),
    .SHUTDOWN_TICKS (SHUTDOWN_TICKS),
    .RESTART_TICKS  (RESTART_TICKS),
    .WINDOW_TICKS   (WINDOW_TICKS),
    .MAX_FAILS      (MAX_FAILS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .deglitchDone (deglitchDone),
    .shutdownDone (shutdownDone),
    .restartDone  (restartDone),
    .windowFull   (windowFull)
  );

endmodule

// File: rtl/uvh_checker.sv
module uvh_checker (
  input logic clk,
  input logic rstN,
  input logic uvFlag,
  input logic uvDisable,
  input logic noHiccup,
  input logic faultWrEn,
  input logic faultWrData,
  input logic convEn,
  input logic clampReq,
  input logic faultBit
);

  p_disable_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    uvDisable |=> (convEn && !clampReq));

  p_clamp_needs_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(clampReq) && !$past(faultBit)) |-> $past(uvFlag));

  p_latch_sets_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultBit) |-> (!convEn && clampReq));

  p_nohiccup_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(noHiccup) && $fell(convEn)) |-> faultBit);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultBit && !(faultWrEn && !faultWrData)) |=> faultBit);

  p_latched_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultBit && !uvDisable && !$past(uvDisable)) |-> !convEn);

  p_clear_resumes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (faultBit && faultWrEn && !faultWrData && !uvDisable) |=> (convEn && !clampReq && !faultBit));

endmodule

bind uv_hiccup_guard uvh_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .uvFlag      (uvFlag),
  .uvDisable   (uvDisable),
  .noHiccup    (noHiccup),
  .faultWrEn   (faultWrEn),
  .faultWrData (faultWrData),
  .convEn      (convEn),
  .clampReq    (clampReq),
  .faultBit    (faultBit)
);

// File: tb/uv_hiccup_guard_tb.sv
module uv_hiccup_guard_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvFlag = 1'b0;
  logic uvDisable = 1'b0;
  logic noHiccup = 1'b0;
  logic faultWrEn = 1'b0;
  logic faultWrData = 1'b0;
  logic convEn, clampReq, faultBit;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    qCyc[$];
  logic [2:0] qVal[$];
  string qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uv_hiccup_guard #(
    .CLKS_PER_TICK  (2),
    .DEGLITCH_TICKS (3),
    .SHUTDOWN_TICKS (8),
    .RESTART_TICKS  (4),
    .WINDOW_TICKS   (30),
    .MAX_FAILS      (3)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .uvFlag      (uvFlag),
    .uvDisable   (uvDisable),
    .noHiccup    (noHiccup),
    .faultWrEn   (faultWrEn),
    .faultWrData (faultWrData),
    .convEn      (convEn),
    .clampReq    (clampReq),
    .faultBit    (faultBit)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Driver side: expected {convEn, clampReq, faultBit} at a given cycle
  task automatic expectAt(input int c, input logic en, input logic cl, input logic ft, input string tag);
    qCyc.push_back(c);
    qVal.push_back({en, cl, ft});
    qTag.push_back(tag);
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor side
  always @(negedge clk) begin
    if (rstN) begin
      while (qCyc.size() > 0 && qCyc[0] <= cyc) begin
        logic [2:0] got;
        got = {convEn, clampReq, faultBit};
        checks++;
        if (qCyc[0] < cyc) begin
          errors++;
          $display("FAIL %s: expectation for cycle %0d missed at %0d, actual %b expected %b",
                   qTag[0], qCyc[0], cyc, got, qVal[0]);
        end else if (got !== qVal[0]) begin
          errors++;
          $display("FAIL %s: cycle %0d {convEn,clampReq,faultBit} actual %b expected %b",
                   qTag[0], cyc, got, qVal[0]);
        end
        void'(qCyc.pop_front());
        void'(qVal.pop_front());
        void'(qTag.pop_front());
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finishRun();
  end

  initial begin
    int n0, m0, d0, c0, q0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    expectAt(1, 1'b1, 1'b0, 1'b0, "R1");
    expectAt(3, 1'b1, 1'b0, 1'b0, "R1");

    // R3: pulse of 4 edges, shorter than the 6-cycle deglitch
    waitCyc(5);
    uvFlag = 1'b1; n0 = cyc + 1;
    expectAt(n0 + 6,  1'b1, 1'b0, 1'b0, "R3");
    expectAt(n0 + 10, 1'b1, 1'b0, 1'b0, "R3");
    waitCyc(n0 + 3); uvFlag = 1'b0;

    // R3/R4/R5/R6: one-cycle dropout restarts deglitch, then recovery
    waitCyc(n0 + 14);
    uvFlag = 1'b1; m0 = cyc + 1;
    expectAt(m0 + 9,  1'b1, 1'b0, 1'b0, "R3");
    expectAt(m0 + 10, 1'b0, 1'b1, 1'b0, "R4");
    expectAt(m0 + 25, 1'b0, 1'b1, 1'b0, "R5");
    expectAt(m0 + 26, 1'b1, 1'b1, 1'b0, "R5");
    expectAt(m0 + 34, 1'b1, 1'b0, 1'b0, "R6");
    waitCyc(m0 + 2); uvFlag = 1'b0;
    waitCyc(m0 + 3); uvFlag = 1'b1;
    waitCyc(m0 + 11); uvFlag = 1'b0;
    waitCyc(m0 + 36);

    // R2: disabled protection ignores a sustained low rail
    uvDisable = 1'b1; uvFlag = 1'b1; d0 = cyc + 1;
    expectAt(d0 + 2,  1'b1, 1'b0, 1'b0, "R2");
    expectAt(d0 + 10, 1'b1, 1'b0, 1'b0, "R2");
    expectAt(d0 + 20, 1'b1, 1'b0, 1'b0, "R2");
    expectAt(d0 + 24, 1'b1, 1'b0, 1'b0, "R2");
    waitCyc(d0 + 20); uvFlag = 1'b0; uvDisable = 1'b0;
    waitCyc(d0 + 26);

    // R5/R6/R7/R9/R10: three failures 12 ticks apart latch off
    uvFlag = 1'b1; n0 = cyc + 1;
    expectAt(n0 + 5,  1'b1, 1'b0, 1'b0, "R3");
    expectAt(n0 + 6,  1'b0, 1'b1, 1'b0, "R5");
    expectAt(n0 + 21, 1'b0, 1'b1, 1'b0, "R5");
    expectAt(n0 + 22, 1'b1, 1'b1, 1'b0, "R5");
    expectAt(n0 + 29, 1'b1, 1'b1, 1'b0, "R5");
    expectAt(n0 + 30, 1'b0, 1'b1, 1'b0, "R6");
    expectAt(n0 + 54, 1'b0, 1'b1, 1'b0, "R7");
    expectAt(n0 + 77, 1'b1, 1'b1, 1'b0, "R7");
    expectAt(n0 + 78, 1'b0, 1'b1, 1'b1, "R7");
    expectAt(n0 + 84, 1'b0, 1'b1, 1'b1, "R9");
    expectAt(n0 + 88, 1'b0, 1'b1, 1'b1, "R9");
    expectAt(n0 + 91, 1'b1, 1'b0, 1'b0, "R10");
    expectAt(n0 + 95, 1'b1, 1'b0, 1'b0, "R10");
    waitCyc(n0 + 80); uvFlag = 1'b0;
    waitCyc(n0 + 85); faultWrEn = 1'b1; faultWrData = 1'b1;
    waitCyc(n0 + 86); faultWrEn = 1'b0;
    waitCyc(n0 + 90); faultWrEn = 1'b1; faultWrData = 1'b0;
    waitCyc(n0 + 91); faultWrEn = 1'b0;
    waitCyc(n0 + 98);

    // R6/R7: recovery spreads failures beyond the window, then three close ones latch
    uvFlag = 1'b1; n0 = cyc + 1;
    expectAt(n0 + 30,  1'b0, 1'b1, 1'b0, "R6");
    expectAt(n0 + 54,  1'b0, 1'b1, 1'b0, "R6");
    expectAt(n0 + 75,  1'b1, 1'b1, 1'b0, "R6");
    expectAt(n0 + 78,  1'b1, 1'b0, 1'b0, "R6");
    expectAt(n0 + 110, 1'b0, 1'b1, 1'b0, "R7");
    expectAt(n0 + 134, 1'b0, 1'b1, 1'b0, "R7");
    expectAt(n0 + 157, 1'b1, 1'b1, 1'b0, "R7");
    expectAt(n0 + 158, 1'b0, 1'b1, 1'b1, "R7");
    waitCyc(n0 + 74); uvFlag = 1'b0;
    waitCyc(n0 + 79); uvFlag = 1'b1;
    waitCyc(n0 + 160);

    // R11: disable releases converter but fault stays; re-enable relatches
    uvDisable = 1'b1; c0 = cyc;
    expectAt(c0 + 1, 1'b1, 1'b0, 1'b1, "R11");
    expectAt(c0 + 3, 1'b1, 1'b0, 1'b1, "R11");
    expectAt(c0 + 5, 1'b0, 1'b1, 1'b1, "R11");
    expectAt(c0 + 7, 1'b1, 1'b0, 1'b0, "R10");
    waitCyc(c0 + 4); uvDisable = 1'b0;
    waitCyc(c0 + 6); uvFlag = 1'b0; faultWrEn = 1'b1; faultWrData = 1'b0;
    waitCyc(c0 + 7); faultWrEn = 1'b0;
    waitCyc(c0 + 10);

    // R8: no-hiccup latches straight after deglitch, no retry
    noHiccup = 1'b1; uvFlag = 1'b1; q0 = cyc + 1;
    expectAt(q0 + 5,  1'b1, 1'b0, 1'b0, "R8");
    expectAt(q0 + 6,  1'b0, 1'b1, 1'b1, "R8");
    expectAt(q0 + 30, 1'b0, 1'b1, 1'b1, "R8");
    expectAt(q0 + 32, 1'b1, 1'b0, 1'b0, "R10");
    waitCyc(q0 + 31); uvFlag = 1'b0; faultWrEn = 1'b1; faultWrData = 1'b0;
    waitCyc(q0 + 32); faultWrEn = 1'b0; noHiccup = 1'b0;
    waitCyc(q0 + 40);

    while (qCyc.size() > 0) @(negedge clk);
    finishRun();
  end

endmodule